// File: doc/BRIEF.md
# Luma Macroblock Framer

This block sits at the front of a block-based video encoder. Eight-bit luma samples arrive in raster order, one per clock, each qualified by a valid strobe. The block regroups them into 16×16 macroblocks. A frame begins on a rising edge of the frame-start input. The frame width and height are runtime inputs, and both must be multiples of 16.

Incoming lines are written into a two-bank line store. Each bank holds one band of 16 lines. While one band fills, a read sequencer walks the other band one tile at a time. It visits the tiles from left to right. Within a tile it reads rows from top to bottom, and within a row it reads columns from left to right. The samples leave on a registered output stream. A start pulse marks the first sample of each macroblock. A flag marks every sample of the bottom-right macroblock of the frame.

Top module: `luma_mb_framer`

## Requirements
- R1: After the synchronous active-high reset, `mb_valid`, `mb_start` and `mb_last` are low, and they stay low until a band of samples has been taken in.
- R2: A sample is taken in only on a cycle where `pix_valid` is high. Cycles with `pix_valid` low do not advance the raster position.
- R3: A frame begins on a 0-to-1 transition of `frame_start`. The sample that arrives on the cycle of that transition is pixel (0,0). Holding `frame_start` high on later cycles does not restart the frame.
- R4: Samples that arrive before the first rising edge of `frame_start` after reset are discarded and produce no output.
- R5: After `frame_end` is seen high, samples are discarded until the next rising edge of `frame_start`. A band left partly filled is never emitted.
- R6: `hres` (at most MAX_W) and `vres` are sampled at run time. Frames of different sizes can follow one another without a reset.
- R7: Output order is as follows. Bands go from top to bottom. Within a band, macroblocks go from left to right. Within a macroblock, rows go from top to bottom, and columns go from left to right within each row. For output index i of a frame of width H, the sample is the one at x = 16·m + c and y = 16·b + r, where b = i / (16H), m = (i mod 16H) / 256, r = (i mod 256) / 16 and c = i mod 16.
- R8: Each macroblock occupies 256 consecutive cycles with `mb_valid` high. `mb_start` is high only on the first of those cycles.
- R9: `mb_last` is high on all 256 samples of the rightmost macroblock of the bottom band, and low on every other sample.
- R10: An unbroken input stream at one sample per clock is absorbed with no sample lost.
- R11: A complete frame yields exactly `hres`·`vres` output samples, and no output appears beyond them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Frame marker; its rising edge opens a frame |
| frame_end | input | 1 | Closes the current frame |
| pix_valid | input | 1 | Qualifies `pix_y` |
| pix_y | input | PIX_W | Luma sample in raster order |
| hres | input | RES_W | Frame width in samples, a multiple of 16 |
| vres | input | RES_W | Frame height in lines, a multiple of 16 |
| mb_valid | output | 1 | Output sample valid |
| mb_data | output | PIX_W | Reordered luma sample |
| mb_start | output | 1 | First sample of a macroblock |
| mb_last | output | 1 | Sample belongs to the final macroblock of the frame |

## Verification
On every cycle the checker enforces the shape of the output stream. Nothing is emitted before any frame has started. Each start pulse opens an unbroken run of 256 valid samples, and no valid sample falls outside such a run. The last-macroblock flag appears only with valid data and stays constant inside a macroblock. The correctness of the reordering, the sample counts per frame, and the discarding of samples around frame boundaries can only be shown by the bench scenarios. These scenarios compare every output sample against raster positions computed for several frame sizes, with and without input gaps.

// File: rtl/lmf_pkg.sv
package lmf_pkg;
  localparam int unsigned MB_DIM = 16;
  localparam int unsigned MB_LG  = 4;

  typedef struct packed {
    logic bank;
    logic last;
  } band_info_t;
endpackage

// File: rtl/lmf_band_ram.sv
module lmf_band_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lmf_wr_ctrl.sv
module lmf_wr_ctrl
  import lmf_pkg::*;
#(
  parameter int unsigned CW = 6,
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          pix_valid,
  input  logic [RW-1:0] hres,
  input  logic [RW-1:0] vres,
  output logic          we,
  output logic [CW+MB_LG:0] waddr,
  output logic          band_done,
  output band_info_t    band_info
);
  logic          fs_q;
  logic          armed;
  logic [RW-1:0] x_q, y_q;
  logic [RW-1:0] cur_x, cur_y;
  logic          sof, take, eol, eob, eof;

  always_comb begin
    sof   = frame_start & ~fs_q;
    cur_x = sof ? '0 : x_q;
    cur_y = sof ? '0 : y_q;
    take  = pix_valid & (sof | armed);
    eol   = (cur_x == hres - RW'(1));
    eob   = eol & (&cur_y[MB_LG-1:0]);
    eof   = eol & (cur_y == vres - RW'(1));
    we    = take;
    waddr = {cur_y[MB_LG], cur_y[MB_LG-1:0], cur_x[CW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q      <= 1'b0;
      armed     <= 1'b0;
      x_q       <= '0;
      y_q       <= '0;
      band_done <= 1'b0;
      band_info <= '0;
    end else begin
      fs_q      <= frame_start;
      band_done <= take & eob;
      if (take & eob) begin
        band_info.bank <= cur_y[MB_LG];
        band_info.last <= eof;
      end

      if (sof)            armed <= 1'b1;
      else if (frame_end) armed <= 1'b0;
      if (take & eof)     armed <= 1'b0;

      if (take) begin
        if (eol) begin
          x_q <= '0;
          y_q <= cur_y + RW'(1);
        end else begin
          x_q <= cur_x + RW'(1);
          y_q <= cur_y;
        end
      end else if (sof) begin
        x_q <= '0;
        y_q <= '0;
      end
    end
  end
endmodule

// File: rtl/lmf_rd_seq.sv
module lmf_rd_seq
  import lmf_pkg::*;
#(
  parameter int unsigned CW = 6,
  parameter int unsigned RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          band_done,
  input  band_info_t    band_info,
  input  logic [RW-1:0] hres,
  output logic          re,
  output logic [CW+MB_LG:0] raddr,
  output logic          out_valid,
  output logic          out_start,
  output logic          out_last
);
  logic             pend;
  band_info_t       pend_info;
  logic             busy, bank, last_band;
  logic [MB_LG-1:0] row, col;
  logic [CW-1:0]    col_base;
  logic             end_row, end_mb, last_mb, end_band;

  always_comb begin
    end_row  = &col;
    end_mb   = end_row & (&row);
    last_mb  = ({{(RW-CW){1'b0}}, col_base} == hres - RW'(MB_DIM));
    end_band = end_mb & last_mb;
    re       = busy;
    raddr    = {bank, row, col_base | {{(CW-MB_LG){1'b0}}, col}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_info <= '0;
      busy      <= 1'b0;
      bank      <= 1'b0;
      last_band <= 1'b0;
      row       <= '0;
      col       <= '0;
      col_base  <= '0;
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= busy;
      out_start <= busy & (row == '0) & (col == '0);
      out_last  <= busy & last_band & last_mb;

      if (!busy && pend) begin
        busy      <= 1'b1;
        pend      <= 1'b0;
        bank      <= pend_info.bank;
        last_band <= pend_info.last;
        row       <= '0;
        col       <= '0;
        col_base  <= '0;
      end else if (busy) begin
        col <= col + 1'b1;
        if (end_row) row <= row + 1'b1;
        if (end_mb)  col_base <= col_base + CW'(MB_DIM);
        if (end_band) busy <= 1'b0;
      end

      if (band_done) begin
        pend      <= 1'b1;
        pend_info <= band_info;
      end
    end
  end
endmodule

// File: rtl/luma_mb_framer.sv
module luma_mb_framer
  import lmf_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned MAX_W = 64,
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_y,
  input  logic [RES_W-1:0] hres,
  input  logic [RES_W-1:0] vres,
  output logic             mb_valid,
  output logic [PIX_W-1:0] mb_data,
  output logic             mb_start,
  output logic             mb_last
);
  localparam int unsigned CW = $clog2(MAX_W);
  localparam int unsigned AW = CW + MB_LG + 1;

  logic          we, re, band_done;
  logic [AW-1:0] waddr, raddr;
  band_info_t    band_info;

  lmf_wr_ctrl #(.CW(CW), .RW(RES_W)) wr_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
    .pix_valid(pix_valid), .hres(hres), .vres(vres),
    .we(we), .waddr(waddr), .band_done(band_done), .band_info(band_info)
  );

  lmf_band_ram #(.DW(PIX_W), .AW(AW)) ram_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(pix_y),
    .re(re), .raddr(raddr), .rdata(mb_data)
  );

  lmf_rd_seq #(.CW(CW), .RW(RES_W)) rd_i (
    .clk(clk), .rst(rst), .band_done(band_done), .band_info(band_info),
    .hres(hres), .re(re), .raddr(raddr),
    .out_valid(mb_valid), .out_start(mb_start), .out_last(mb_last)
  );
endmodule

// File: rtl/lmf_chk.sv
module lmf_chk #(
  parameter int unsigned MBD = 16
) (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic mb_valid,
  input logic mb_start,
  input logic mb_last
);
  localparam int unsigned NS = MBD * MBD;
  localparam int unsigned RUNW = $clog2(NS);

  logic            seen;
  logic [RUNW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      run  <= '0;
    end else begin
      if (frame_start) seen <= 1'b1;
      if (mb_start) run <= RUNW'(1);
      else if (run != '0) run <= (run == RUNW'(NS - 1)) ? '0 : run + 1'b1;
    end
  end

  assert_quiet_before_frame_R4: assert property (@(posedge clk) disable iff (rst)
    !seen |-> !mb_valid);

  assert_start_opens_burst_R8: assert property (@(posedge clk) disable iff (rst)
    mb_start |-> (mb_valid && run == '0));

  assert_no_gap_in_mb_R8: assert property (@(posedge clk) disable iff (rst)
    (run != '0) |-> mb_valid);

  assert_valid_inside_mb_R8: assert property (@(posedge clk) disable iff (rst)
    (mb_valid && !mb_start) |-> (run != '0));

  assert_last_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
    mb_last |-> mb_valid);

  assert_last_steady_in_mb_R9: assert property (@(posedge clk) disable iff (rst)
    (mb_valid && !mb_start) |-> (mb_last == $past(mb_last)));
endmodule

bind luma_mb_framer lmf_chk #(.MBD(16)) chk_i (
  .clk(clk), .rst(rst), .frame_start(frame_start),
  .mb_valid(mb_valid), .mb_start(mb_start), .mb_last(mb_last)
);

// File: tb/luma_mb_framer_tb_top.sv
`timescale 1ns/1ps
module luma_mb_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        frame_end = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_y = '0;
  logic [15:0] hres = 16'd32;
  logic [15:0] vres = 16'd32;
  logic        mb_valid, mb_start, mb_last;
  logic [7:0]  mb_data;

  always #2.5 clk = ~clk;

  luma_mb_framer #(.PIX_W(8), .MAX_W(64), .RES_W(16)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
    .pix_valid(pix_valid), .pix_y(pix_y), .hres(hres), .vres(vres),
    .mb_valid(mb_valid), .mb_data(mb_data), .mb_start(mb_start), .mb_last(mb_last)
  );

  int checks = 0, errors = 0;
  int exp_h = 32, exp_v = 32, exp_f = 0, total = 0, out_idx = 0;
  bit done = 1'b0;

  function automatic int pix(int x, int y, int f);
    return (x * 3 + y * 29 + f * 71 + 5) % 256;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Output monitor: R7 order, R8 start, R9 last flag, R11 no extra output
  always @(negedge clk) begin
    if (!rst && mb_valid) begin
      int per_band, b, rem, m, w, r, c;
      per_band = 16 * exp_h;
      b   = out_idx / per_band;
      rem = out_idx % per_band;
      m   = rem / 256;
      w   = rem % 256;
      r   = w / 16;
      c   = w % 16;
      if (out_idx >= total) begin
        chk(1'b0, "R11 extra output index", out_idx, total);
      end else begin
        chk(int'(mb_data) == pix(m * 16 + c, b * 16 + r, exp_f), "R7 sample value",
            int'(mb_data), pix(m * 16 + c, b * 16 + r, exp_f));
        chk(mb_start == (w == 0), "R8 start pulse", int'(mb_start), int'(w == 0));
        chk(mb_last == (b == exp_v / 16 - 1 && m == exp_h / 16 - 1), "R9 last flag",
            int'(mb_last), int'(b == exp_v / 16 - 1 && m == exp_h / 16 - 1));
      end
      out_idx++;
    end
  end

  // Drive rows [y0, y0+rows) of a frame; fs high for the first fs_hold cycles.
  task automatic send_rows(input int h, input int y0, input int rows, input int f,
                           input int fs_hold, input bit gaps);
    int n = 0;
    for (int y = y0; y < y0 + rows; y++) begin
      for (int x = 0; x < h; x++) begin
        if (gaps && (x % 3 == 1)) begin
          @(negedge clk);
          frame_start = (n < fs_hold);
          pix_valid = 1'b0;
          pix_y = 8'h5A;
          n++;
        end
        @(negedge clk);
        frame_start = (n < fs_hold);
        pix_valid = 1'b1;
        pix_y = 8'(pix(x, y, f));
        n++;
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
    frame_start = 1'b0;
  endtask

  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b1;
      pix_y = 8'hAA;
    end
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic finish_frame(input string req);
    int guard = 0;
    while (out_idx < total && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (700) @(negedge clk);
    chk(out_idx == total, req, out_idx, total);
  endtask

  task automatic run_frame(input int h, input int v, input int f, input int fs_hold,
                           input bit gaps, input string req);
    @(negedge clk);
    hres = 16'(h); vres = 16'(v);
    exp_h = h; exp_v = v; exp_f = f; total = h * v; out_idx = 0;
    send_rows(h, 0, v, f, fs_hold, gaps);
    finish_frame(req);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(mb_valid == 1'b0 && mb_start == 1'b0 && mb_last == 1'b0, "R1 reset outputs",
        int'({mb_valid, mb_start, mb_last}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(mb_valid == 1'b0, "R1 idle after reset", int'(mb_valid), 0);

    // R4: samples before any frame start are dropped
    total = 0; out_idx = 0;
    junk(600);
    repeat (600) @(negedge clk);
    chk(out_idx == 0, "R4 no output before frame start", out_idx, 0);

    run_frame(32, 32, 1, 1, 1'b0, "R11 count 32x32");
    // R3: frame_start held high for several cycles does not restart
    run_frame(48, 16, 2, 5, 1'b0, "R3 count with held start 48x16");
    // R2: gaps in the valid strobe
    run_frame(16, 48, 3, 1, 1'b1, "R2 count with input gaps 16x48");
    // R10 / R6: widest frame at full rate, then a resize
    run_frame(64, 32, 4, 1, 1'b0, "R10 count full rate 64x32");

    // R5: frame_end truncates; later samples ignored, partial band not emitted
    @(negedge clk);
    hres = 16'd32; vres = 16'd32;
    exp_h = 32; exp_v = 32; exp_f = 5; total = 512; out_idx = 0;
    send_rows(32, 0, 16, 5, 1, 1'b0);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    send_rows(32, 16, 16, 5, 0, 1'b0);
    finish_frame("R5 output stops after frame end");

    run_frame(32, 16, 6, 2, 1'b0, "R6 count after resize 32x16");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule